// File: doc/BRIEF.md
# Global-Shutter Frame and Line Readout Sequencer

This block generates the readout timing for a global-shutter pixel array of 480 lines by 640 columns. A frame-start request, raised by the exposure controller at its frame-transfer event, opens a frame. The frame opens with a frame overhead phase, during which the analog pixel values move into in-pixel storage. Lines are then read in ascending order. Each line opens with a row overhead phase, during which the addressed row drives the column lines. The columns are then selected four at a time, so each line is read as 160 kernels.

All sequencing advances on a core tick. The tick is an enable that is high on one input clock in every four, and the converters use the same cadence. Every output is registered, changes only on a ticked edge, and holds for one full core cycle. Integration of the next frame runs in parallel outside this block, so a request that arrives during readout is held until the current frame completes. The block then emits a line-done pulse after each line and a frame-done pulse after the last line.

Top module: `pixel_readout_seq`

## Requirements
- R1: `core_tick` is high on exactly one input clock in every CORE_DIV (default 4), and every other output changes only on an input clock edge at which `core_tick` is high.
- R2: While reset is held, and right after it is released, all strobes and phase flags are 0 and `row_idx` and `kern_idx` are 0.
- R3: With no request pending, the block stays idle and `fot_active` stays 0. A request pulse starts the frame overhead within CORE_DIV+1 input clocks.
- R4: `fot_active` is high for exactly FOT_CYC core cycles (default 32, which is 128 input clocks). It is followed directly by the row overhead of line 0.
- R5: A frame reads ROWS lines (default 480), numbered 0 upward. `row_sel` is high for the first core cycle of each row overhead, with `row_idx` equal to that line's number, and `row_idx` never exceeds ROWS-1.
- R6: `rot_active` is high for exactly ROT_CYC core cycles per line (default 8, which is 32 input clocks). The kernel phase follows directly.
- R7: In each line, `kern_sel` is high for KERNELS consecutive core cycles (default 160). `kern_idx` steps from 0 to KERNELS-1, one value per core cycle.
- R8: `line_done` is high for exactly the one core cycle that follows the core cycle with `kern_idx` = KERNELS-1.
- R9: `frame_done` is high together with the `line_done` of the last line, and only then. The block then goes idle unless a request is pending.
- R10: A request raised during a frame is held. Several such requests merge into one. The next frame overhead begins at the ticked edge that ends the `frame_done` core cycle.
- R11: At most one of `fot_active`, `rot_active` and `kern_sel` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_req | input | 1 | Frame-start request from the exposure controller, one clock or longer |
| core_tick | output | 1 | Core clock enable, one input clock in every CORE_DIV |
| fot_active | output | 1 | Frame overhead phase in progress |
| rot_active | output | 1 | Row overhead phase in progress |
| row_sel | output | 1 | First core cycle of a line, `row_idx` valid |
| row_idx | output | $clog2(ROWS) | Line being read |
| kern_sel | output | 1 | Kernel select strobe, one per core cycle |
| kern_idx | output | $clog2(KERNELS) | Four-column group being selected |
| line_done | output | 1 | One core cycle after the last kernel of a line |
| frame_done | output | 1 | With the line-done of the last line |

## Verification
The checker watches the invariants on every cycle: the tick spacing, outputs holding between ticks, the exclusive phases, the index ranges, the line end following the last kernel, and the phase hand-offs. Only the directed scenarios show the exact phase lengths in input clocks, the full count of kernel strobes and lines, the ascending index order, the request latency, and the merging of mid-frame requests into exactly one following frame. The bench reduces ROWS so that each frame fits in its run, and keeps the default kernel count and overhead lengths.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FOT  = 2'd1,
        ST_ROT  = 2'd2,
        ST_KERN = 2'd3
    } rdo_state_e;

    function automatic int unsigned safe_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rdo_core_div.sv
module rdo_core_div #(
    parameter int unsigned CORE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned DW = rdo_pkg::safe_w(CORE_DIV);

    generate
        if (CORE_DIV <= 1) begin : g_nodiv
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam logic [DW-1:0] LAST = DW'(CORE_DIV - 1);
            logic [DW-1:0] div_d, div_q;

            always_comb begin
                div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rdo_req_hold.sv
module rdo_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic accept_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    // a fresh request wins over a same-cycle accept, so it is not lost
    always_comb begin
        pend_d = req_i | (pend_q & ~accept_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/rdo_fsm.sv
module rdo_fsm
    import rdo_pkg::*;
#(
    parameter int unsigned ROWS    = 480,
    parameter int unsigned KERNELS = 160,
    parameter int unsigned FOT_CYC = 32,
    parameter int unsigned ROT_CYC = 8,
    localparam int unsigned RW  = safe_w(ROWS),
    localparam int unsigned KW  = safe_w(KERNELS),
    localparam int unsigned OMX = (FOT_CYC > ROT_CYC) ? FOT_CYC : ROT_CYC,
    localparam int unsigned OCW = safe_w(OMX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          pend_i,
    output logic          accept_o,
    output logic          fot_o,
    output logic          rot_o,
    output logic          kern_sel_o,
    output logic          row_sel_o,
    output logic [RW-1:0] row_o,
    output logic [KW-1:0] kern_o,
    output logic          line_done_o,
    output logic          frame_done_o
);
    localparam logic [OCW-1:0] FOT_LAST  = OCW'(FOT_CYC - 1);
    localparam logic [OCW-1:0] ROT_LAST  = OCW'(ROT_CYC - 1);
    localparam logic [RW-1:0]  ROW_LAST  = RW'(ROWS - 1);
    localparam logic [KW-1:0]  KERN_LAST = KW'(KERNELS - 1);

    typedef struct packed {
        rdo_state_e     st;
        logic [OCW-1:0] ocnt;
        logic [RW-1:0]  row;
        logic [KW-1:0]  kern;
        logic           row_sel;
        logic           line_done;
        logic           frame_done;
    } seq_t;

    seq_t seq_d, seq_q;

    assign accept_o = tick_i && (seq_q.st == ST_IDLE) && pend_i;

    always_comb begin
        seq_d = seq_q;
        if (tick_i) begin
            seq_d.row_sel    = 1'b0;
            seq_d.line_done  = 1'b0;
            seq_d.frame_done = 1'b0;
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (pend_i) begin
                        seq_d.st   = ST_FOT;
                        seq_d.ocnt = '0;
                    end
                end
                ST_FOT: begin
                    if (seq_q.ocnt == FOT_LAST) begin
                        seq_d.st      = ST_ROT;
                        seq_d.ocnt    = '0;
                        seq_d.row     = '0;
                        seq_d.row_sel = 1'b1;
                    end else begin
                        seq_d.ocnt = seq_q.ocnt + 1'b1;
                    end
                end
                ST_ROT: begin
                    if (seq_q.ocnt == ROT_LAST) begin
                        seq_d.st   = ST_KERN;
                        seq_d.ocnt = '0;
                        seq_d.kern = '0;
                    end else begin
                        seq_d.ocnt = seq_q.ocnt + 1'b1;
                    end
                end
                ST_KERN: begin
                    if (seq_q.kern == KERN_LAST) begin
                        seq_d.kern      = '0;
                        seq_d.line_done = 1'b1;
                        if (seq_q.row == ROW_LAST) begin
                            seq_d.st         = ST_IDLE;
                            seq_d.row        = '0;
                            seq_d.frame_done = 1'b1;
                        end else begin
                            seq_d.st      = ST_ROT;
                            seq_d.row     = seq_q.row + 1'b1;
                            seq_d.row_sel = 1'b1;
                        end
                    end else begin
                        seq_d.kern = seq_q.kern + 1'b1;
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, ocnt: '0, row: '0, kern: '0,
                       row_sel: 1'b0, line_done: 1'b0, frame_done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fot_o        = (seq_q.st == ST_FOT);
    assign rot_o        = (seq_q.st == ST_ROT);
    assign kern_sel_o   = (seq_q.st == ST_KERN);
    assign row_sel_o    = seq_q.row_sel;
    assign row_o        = seq_q.row;
    assign kern_o       = seq_q.kern;
    assign line_done_o  = seq_q.line_done;
    assign frame_done_o = seq_q.frame_done;
endmodule

// File: rtl/pixel_readout_seq.sv
module pixel_readout_seq #(
    parameter int unsigned ROWS     = 480,
    parameter int unsigned KERNELS  = 160,
    parameter int unsigned FOT_CYC  = 32,
    parameter int unsigned ROT_CYC  = 8,
    parameter int unsigned CORE_DIV = 4,
    localparam int unsigned RW = rdo_pkg::safe_w(ROWS),
    localparam int unsigned KW = rdo_pkg::safe_w(KERNELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_req,
    output logic          core_tick,
    output logic          fot_active,
    output logic          rot_active,
    output logic          row_sel,
    output logic [RW-1:0] row_idx,
    output logic          kern_sel,
    output logic [KW-1:0] kern_idx,
    output logic          line_done,
    output logic          frame_done
);
    logic tick;
    logic pend;
    logic accept;

    rdo_core_div #(.CORE_DIV(CORE_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rdo_req_hold u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (frame_req),
        .accept_i (accept),
        .pend_o   (pend)
    );

    rdo_fsm #(
        .ROWS    (ROWS),
        .KERNELS (KERNELS),
        .FOT_CYC (FOT_CYC),
        .ROT_CYC (ROT_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .pend_i       (pend),
        .accept_o     (accept),
        .fot_o        (fot_active),
        .rot_o        (rot_active),
        .kern_sel_o   (kern_sel),
        .row_sel_o    (row_sel),
        .row_o        (row_idx),
        .kern_o       (kern_idx),
        .line_done_o  (line_done),
        .frame_done_o (frame_done)
    );

    assign core_tick = tick;
endmodule

// File: rtl/pixel_readout_seq_chk.sv
module pixel_readout_seq_chk #(
    parameter int unsigned ROWS     = 480,
    parameter int unsigned KERNELS  = 160,
    parameter int unsigned CORE_DIV = 4,
    parameter int unsigned RW       = 9,
    parameter int unsigned KW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_tick,
    input logic          fot_active,
    input logic          rot_active,
    input logic          row_sel,
    input logic [RW-1:0] row_idx,
    input logic          kern_sel,
    input logic [KW-1:0] kern_idx,
    input logic          line_done,
    input logic          frame_done
);
    generate
        if (CORE_DIV > 1) begin : g_spacing
            // R1
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                core_tick |=> !core_tick);
        end
    endgenerate

    // R1
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_tick |=> $stable({fot_active, rot_active, row_sel, row_idx,
                                kern_sel, kern_idx, line_done, frame_done}));

    // R11
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fot_active, rot_active, kern_sel}));

    // R8
    line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_done) |-> ($past(kern_sel) && (int'($past(kern_idx)) == KERNELS - 1)));

    // R9
    frame_with_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> line_done);

    // R5
    row_sel_in_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel |-> rot_active);

    // R5
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_idx) <= ROWS - 1);

    // R7
    kern_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kern_sel |-> (int'(kern_idx) <= KERNELS - 1));

    // R6
    rot_to_kern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rot_active) |-> kern_sel);

    // R4
    fot_to_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fot_active) |-> (rot_active && row_idx == '0));
endmodule

bind pixel_readout_seq pixel_readout_seq_chk #(
    .ROWS     (ROWS),
    .KERNELS  (KERNELS),
    .CORE_DIV (CORE_DIV),
    .RW       (RW),
    .KW       (KW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_tick  (core_tick),
    .fot_active (fot_active),
    .rot_active (rot_active),
    .row_sel    (row_sel),
    .row_idx    (row_idx),
    .kern_sel   (kern_sel),
    .kern_idx   (kern_idx),
    .line_done  (line_done),
    .frame_done (frame_done)
);

// File: tb/pixel_readout_seq_tb_top.sv
module pixel_readout_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int ROWS  = 6;
    localparam int KERN  = 160;
    localparam int FOT   = 32;
    localparam int ROT   = 8;
    localparam int RW    = $clog2(ROWS);
    localparam int KW    = $clog2(KERN);
    localparam int WD_CYC = 100000;

    logic          clk;
    logic          rst_n;
    logic          frame_req;
    logic          core_tick;
    logic          fot_active;
    logic          rot_active;
    logic          row_sel;
    logic [RW-1:0] row_idx;
    logic          kern_sel;
    logic [KW-1:0] kern_idx;
    logic          line_done;
    logic          frame_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    pixel_readout_seq #(
        .ROWS(ROWS), .KERNELS(KERN), .FOT_CYC(FOT), .ROT_CYC(ROT), .CORE_DIV(DIV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .core_tick(core_tick),
        .fot_active(fot_active), .rot_active(rot_active), .row_sel(row_sel),
        .row_idx(row_idx), .kern_sel(kern_sel), .kern_idx(kern_idx),
        .line_done(line_done), .frame_done(frame_done)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        frame_req = 1'b0;
        repeat (5) @(negedge clk);
        check({fot_active, rot_active, row_sel, kern_sel, line_done, frame_done} == 6'b0,
              "R2", "flags in reset",
              int'({fot_active, rot_active, row_sel, kern_sel, line_done, frame_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(int'(row_idx) == 0 && int'(kern_idx) == 0, "R2", "indexes after reset",
              int'(row_idx) + int'(kern_idx), 0);
        check(!fot_active && !kern_sel, "R2", "idle after reset",
              int'(fot_active) + int'(kern_sel), 0);
    endtask

    task automatic t_divider();
        while (!core_tick) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            int gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!core_tick && gap < 20);
            check(gap == DIV, "R1", "core tick spacing", gap, DIV);
        end
    endtask

    task automatic t_idle();
        int seen = 0;
        repeat (200) begin
            @(negedge clk);
            if (fot_active || kern_sel) seen++;
        end
        check(seen == 0, "R3", "activity without request", seen, 0);
    endtask

    task automatic run_frame(input bit inject);
        int fot_clks = 0, rot_clks = 0, kclks = 0, kexp = 0, kbad = 0;
        int lines = 0, rsel = 0, offtick = 0, multi = 0;
        bit p_fot = 1, p_rot = 0, p_ld = 0, p_ks = 0, p_tick = 1, clr = 0;
        int p_kidx = 0;
        logic [RW+KW+7:0] p_vec, vec;
        p_vec = {fot_active, rot_active, row_sel, row_idx, kern_sel, kern_idx, line_done, frame_done};
        forever begin
            vec = {fot_active, rot_active, row_sel, row_idx, kern_sel, kern_idx, line_done, frame_done};
            if (clr) begin frame_req = 1'b0; clr = 0; end
            if (!p_tick && vec != p_vec) offtick++;
            if (int'(fot_active) + int'(rot_active) + int'(kern_sel) > 1) multi++;
            if (fot_active) fot_clks++;
            if (p_fot && !fot_active) begin
                check(fot_clks == FOT * DIV, "R4", "frame overhead clocks", fot_clks, FOT * DIV);
                check(rot_active, "R4", "row overhead follows", int'(rot_active), 1);
            end
            if (rot_active) rot_clks++;
            if (p_rot && !rot_active) begin
                if (lines == 0)
                    check(rot_clks == ROT * DIV, "R6", "row overhead clocks", rot_clks, ROT * DIV);
                else if (rot_clks != ROT * DIV)
                    check(0, "R6", "row overhead clocks", rot_clks, ROT * DIV);
                check(kern_sel, "R6", "kernels follow row overhead", int'(kern_sel), 1);
                rot_clks = 0;
            end
            if (kern_sel) kclks++;
            if (line_done && !p_ld)
                check(p_ks && p_kidx == KERN - 1, "R8", "line done after last kernel", p_kidx, KERN - 1);
            if (kern_sel && core_tick) begin
                if (int'(kern_idx) != kexp) kbad++;
                kexp++;
            end
            if (line_done && core_tick) begin
                check(kexp == KERN, "R7", "kernel strobes per line", kexp, KERN);
                check(kclks == KERN * DIV && kbad == 0, "R7", "kernel clocks / order errors",
                      kclks + kbad, KERN * DIV);
                check(!kern_sel, "R8", "line done after kernel phase", int'(kern_sel), 0);
                check(frame_done == (lines == ROWS - 1), "R9", "frame done only on last line",
                      int'(frame_done), int'(lines == ROWS - 1));
                lines++;
                kexp = 0; kclks = 0; kbad = 0;
                if (inject && (lines == 1 || lines == 3)) begin
                    frame_req = 1'b1;
                    clr = 1;
                end
            end
            if (row_sel && core_tick) begin
                rsel++;
                check(int'(row_idx) == lines, "R5", "row index on row select", int'(row_idx), lines);
            end
            if (frame_done && core_tick) begin
                check(lines == ROWS, "R5", "lines per frame", lines, ROWS);
                check(rsel == ROWS, "R5", "row selects per frame", rsel, ROWS);
                check(!fot_active, "R9", "no overhead during frame done", int'(fot_active), 0);
                break;
            end
            p_fot = fot_active; p_rot = rot_active; p_ld = line_done; p_ks = kern_sel;
            p_kidx = int'(kern_idx); p_tick = core_tick; p_vec = vec;
            @(negedge clk);
        end
        check(offtick == 0, "R1", "outputs moved off tick", offtick, 0);
        check(multi == 0, "R11", "overlapping phases", multi, 0);
    endtask

    task automatic t_frame(input bit inject);
        int n = 1;
        @(negedge clk);
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        while (!fot_active && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(fot_active && n <= DIV + 1, "R3", "request to overhead clocks", n, DIV + 1);
        run_frame(inject);
    endtask

    task automatic t_back_to_back();
        int seen = 0;
        t_frame(1'b1);
        @(negedge clk);
        check(fot_active, "R10", "held request starts next frame", int'(fot_active), 1);
        run_frame(1'b0);
        repeat (500) begin
            @(negedge clk);
            if (fot_active) seen++;
        end
        check(seen == 0, "R10", "merged requests gave extra frame", seen, 0);
    endtask

    task automatic t_single_then_idle();
        int seen = 0;
        t_frame(1'b0);
        repeat (300) begin
            @(negedge clk);
            if (fot_active || kern_sel) seen++;
        end
        check(seen == 0, "R9", "idle after frame without request", seen, 0);
    endtask

    initial begin
        t_reset();
        t_divider();
        t_idle();
        t_single_then_idle();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule